// File: doc/BRIEF.md
# Match-Line Refresh Period Controller

This controller schedules the precharge of the match lines in a search array. The array is split into several narrow partial match blocks. Between two full precharges, a block can serve a limited number of searches. After each accepted search, only the rows that hit are recharged, because rows that missed still hold their charge. The controller keeps a search count for each block. When a block has used its allowance, the controller raises that block's full-precharge strobe for one cycle, and the block accepts no search in that cycle.

The allowance, or refresh period, depends on two things: the block width and the tolerance mode in force for that block. The modes are exact matching, 1-bit Hamming tolerance and 2-bit Hamming tolerance. A wider allowance lets more charge leak away before the next refresh, so a relaxed block accepts near matches. A configuration write sets how many low-order blocks run relaxed and at which tolerance. All higher blocks stay exact. A transistor-free crossbar build uses slightly shorter relaxed periods.

Each block runs its own three-state machine:
- `ST_CHARGE` is the full-precharge cycle. It always moves to `ST_SEARCH` unless a configuration write keeps it there.
- `ST_SEARCH` counts accepted searches. It moves to `ST_LAST` when only one search of the period is left.
- `ST_LAST` moves to `ST_CHARGE` on the next accepted search.
- A configuration write sends every block to `ST_CHARGE` from any state.

Top module: `mlr_refresh_ctrl`

## Requirements
- R1: In the first cycle after reset is released, every block asserts its full-precharge strobe, every mode field reads exact (00), and the recharge mask is all zero.
- R2: A full-precharge strobe lasts one cycle unless a configuration write repeats it. While a block's strobe is high, its search-accept output is low, and a search strobe in that cycle does not count toward its period.
- R3: In exact mode the period is 4 searches for blocks of width 8 or more, 5 for widths 4 to 7, and 7 for narrower blocks.
- R4: With 1-bit tolerance the period is the exact period plus 2 (plus 1 in the crossbar build). With 2-bit tolerance it is the exact period plus 4 (plus 3 in the crossbar build).
- R5: The full-precharge strobe of a block rises in the cycle after the accepted search that completes its period.
- R6: The mode output holds 2 bits per block at bits [2b+1:2b], encoded 00 exact, 01 one-bit, 10 two-bit. Block b is relaxed exactly when b is less than the configured relax count (counts of NUM_BLK or more relax all blocks). The level bit selects one-bit (0) or two-bit (1) tolerance.
- R7: A configuration write forces a full precharge of all blocks in the next cycle, and the new modes show from that cycle.
- R8: Recharge mask bit b*ROWS+r equals hit input bit b*ROWS+r when block b accepted a search in the previous cycle and is not precharging now. Otherwise the bit is 0.
- R9: Cycles without a search strobe leave every block's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_i | input | 1 | Search strobe for all blocks |
| hit_i | input | NUM_BLK*ROWS | Per-block, per-row hits of the previous search |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_relax_i | input | RLX_W | Number of low-order blocks to relax |
| cfg_lvl_i | input | 1 | Relaxed tolerance: 0 one-bit, 1 two-bit |
| pc_full_o | output | NUM_BLK | Per-block full-precharge strobe |
| srch_ok_o | output | NUM_BLK | Block accepts a search this cycle |
| rcg_mask_o | output | NUM_BLK*ROWS | Selective recharge mask |
| blk_mode_o | output | 2*NUM_BLK | Tolerance mode in force per block |

## Verification
The hardest case to reach is a mixed configuration: relaxed and exact blocks, with their different periods, drifting out of phase under irregular search traffic. In that state a configuration write must cut every count at an arbitrary point. The bench sweeps every relax count from 0 to beyond the block count at both levels. It drives three widths and both cell variants side by side. Pseudo-random search gaps keep the blocks out of step, and each write lands mid-period. An idle stretch after each write shows that counts hold without searches.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

    typedef enum logic [1:0] {
        ST_CHARGE = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LAST   = 2'd2
    } blk_st_e;

    typedef enum logic [1:0] {
        MODE_EXACT = 2'b00,
        MODE_HD1   = 2'b01,
        MODE_HD2   = 2'b10
    } tol_e;

    // exact-match allowance as a function of block width
    function automatic int unsigned exact_period(int unsigned w);
        if (w >= 8) return 4;
        else if (w >= 4) return 5;
        else return 7;
    endfunction

    // allowance for a tolerance mode; crossbar cells leak more
    function automatic int unsigned tol_period(int unsigned w, bit xb, tol_e m);
        int unsigned p;
        p = exact_period(w);
        case (m)
            MODE_HD1: p = p + (xb ? 1 : 2);
            MODE_HD2: p = p + (xb ? 3 : 4);
            default:  p = p;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mlr_cfg_reg.sv
module mlr_cfg_reg
    import mlr_pkg::*;
#(
    parameter int NUM_BLK = 4,
    parameter int RLX_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_i,
    input  logic [RLX_W-1:0]       cfg_relax_i,
    input  logic                   cfg_lvl_i,
    output logic [2*NUM_BLK-1:0]   mode_o
);

    logic [RLX_W-1:0] relax_q;
    logic             lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relax_q <= '0;
            lvl_q   <= 1'b0;
        end else if (cfg_wr_i) begin
            relax_q <= cfg_relax_i;
            lvl_q   <= cfg_lvl_i;
        end
    end

    // low-order blocks are relaxed first
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_mode
        localparam logic [RLX_W-1:0] IDX = RLX_W'(b);
        tol_e blk_mode;
        always_comb begin
            if (IDX < relax_q) begin
                blk_mode = lvl_q ? MODE_HD2 : MODE_HD1;
            end else begin
                blk_mode = MODE_EXACT;
            end
        end
        assign mode_o[2*b +: 2] = blk_mode;
    end

endmodule

// File: rtl/mlr_blk_fsm.sv
module mlr_blk_fsm
    import mlr_pkg::*;
#(
    parameter int BLK_W = 8,
    parameter bit XBAR  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       srch_i,
    input  logic       force_i,
    input  logic [1:0] mode_i,
    output logic       pc_o,
    output logic       ok_o,
    output logic       acc_q_o
);

    localparam int unsigned P_EX  = tol_period(BLK_W, XBAR, MODE_EXACT);
    localparam int unsigned P_H1  = tol_period(BLK_W, XBAR, MODE_HD1);
    localparam int unsigned P_H2  = tol_period(BLK_W, XBAR, MODE_HD2);
    localparam int unsigned CNT_W = $clog2(P_H2 + 1);

    blk_st_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_idx;
    logic             acc_d;

    // index of the final search of the period
    always_comb begin
        unique case (tol_e'(mode_i))
            MODE_HD1: last_idx = CNT_W'(P_H1 - 1);
            MODE_HD2: last_idx = CNT_W'(P_H2 - 1);
            default:  last_idx = CNT_W'(P_EX - 1);
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CHARGE;
            cnt_q   <= '0;
            acc_q_o <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            acc_q_o <= acc_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_d   = 1'b0;
        unique case (state_q)
            ST_CHARGE: begin
                cnt_d   = '0;
                state_d = (last_idx == '0) ? ST_LAST : ST_SEARCH;
            end
            ST_SEARCH: begin
                if (srch_i) begin
                    acc_d = 1'b1;
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q + 1'b1 == last_idx) begin
                        state_d = ST_LAST;
                    end
                end
            end
            ST_LAST: begin
                if (srch_i) begin
                    acc_d   = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_CHARGE;
                end
            end
            default: begin
                state_d = ST_CHARGE;
                cnt_d   = '0;
            end
        endcase
        if (force_i) begin
            state_d = ST_CHARGE;
            cnt_d   = '0;
        end
    end

    // outputs
    always_comb begin
        pc_o = 1'b0;
        ok_o = 1'b0;
        unique case (state_q)
            ST_CHARGE: pc_o = 1'b1;
            ST_SEARCH: ok_o = 1'b1;
            ST_LAST:   ok_o = 1'b1;
            default:   pc_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/mlr_rcg_mask.sv
module mlr_rcg_mask #(
    parameter int ROWS = 8
) (
    input  logic [ROWS-1:0] hit_i,
    input  logic            acc_q_i,
    input  logic            pc_i,
    output logic [ROWS-1:0] mask_o
);

    logic gate;
    assign gate = acc_q_i & ~pc_i;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign mask_o[r] = hit_i[r] & gate;
    end

endmodule

// File: rtl/mlr_refresh_ctrl.sv
module mlr_refresh_ctrl
    import mlr_pkg::*;
#(
    parameter int NUM_BLK = 4,
    parameter int ROWS    = 8,
    parameter int BLK_W   = 8,
    parameter bit XBAR    = 1'b0,
    localparam int RLX_W  = $clog2(NUM_BLK + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      srch_i,
    input  logic [NUM_BLK*ROWS-1:0]   hit_i,
    input  logic                      cfg_wr_i,
    input  logic [RLX_W-1:0]          cfg_relax_i,
    input  logic                      cfg_lvl_i,
    output logic [NUM_BLK-1:0]        pc_full_o,
    output logic [NUM_BLK-1:0]        srch_ok_o,
    output logic [NUM_BLK*ROWS-1:0]   rcg_mask_o,
    output logic [2*NUM_BLK-1:0]      blk_mode_o
);

    logic [NUM_BLK-1:0] acc_q;

    mlr_cfg_reg #(
        .NUM_BLK (NUM_BLK),
        .RLX_W   (RLX_W)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_relax_i (cfg_relax_i),
        .cfg_lvl_i   (cfg_lvl_i),
        .mode_o      (blk_mode_o)
    );

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        mlr_blk_fsm #(
            .BLK_W (BLK_W),
            .XBAR  (XBAR)
        ) i_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .srch_i  (srch_i),
            .force_i (cfg_wr_i),
            .mode_i  (blk_mode_o[2*b +: 2]),
            .pc_o    (pc_full_o[b]),
            .ok_o    (srch_ok_o[b]),
            .acc_q_o (acc_q[b])
        );

        mlr_rcg_mask #(
            .ROWS (ROWS)
        ) i_mask (
            .hit_i   (hit_i[b*ROWS +: ROWS]),
            .acc_q_i (acc_q[b]),
            .pc_i    (pc_full_o[b]),
            .mask_o  (rcg_mask_o[b*ROWS +: ROWS])
        );
    end

endmodule

// File: rtl/mlr_refresh_chk.sv
module mlr_refresh_chk #(
    parameter int NUM_BLK = 4,
    parameter int ROWS    = 8,
    parameter int MAXP    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    srch_i,
    input logic                    cfg_wr_i,
    input logic [NUM_BLK-1:0]      pc_full_o,
    input logic [NUM_BLK-1:0]      srch_ok_o,
    input logic [NUM_BLK*ROWS-1:0] rcg_mask_o,
    input logic [2*NUM_BLK-1:0]    blk_mode_o
);

    assert_cfg_forces_charge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> (&pc_full_o));

    assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(blk_mode_o));

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_chk
        logic [7:0] used_q;

        always_ff @(posedge clk) begin
            if (!rst_n || pc_full_o[b] || cfg_wr_i) begin
                used_q <= '0;
            end else if (srch_i && srch_ok_o[b] && used_q != 8'hff) begin
                used_q <= used_q + 1'b1;
            end
        end

        assert_charge_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pc_full_o[b] && !cfg_wr_i) |=> !pc_full_o[b]);

        assert_period_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
            32'(used_q) <= MAXP);

        assert_mask_quiet_in_charge_R8: assert property (@(posedge clk) disable iff (!rst_n)
            pc_full_o[b] |-> (rcg_mask_o[b*ROWS +: ROWS] == '0));

        assert_mask_after_search_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (|rcg_mask_o[b*ROWS +: ROWS]) |-> ($past(srch_i) && $past(srch_ok_o[b])));
    end

endmodule

bind mlr_refresh_ctrl mlr_refresh_chk #(
    .NUM_BLK (NUM_BLK),
    .ROWS    (ROWS),
    .MAXP    (int'(mlr_pkg::exact_period(BLK_W)) + 4)
) i_mlr_refresh_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_i     (srch_i),
    .cfg_wr_i   (cfg_wr_i),
    .pc_full_o  (pc_full_o),
    .srch_ok_o  (srch_ok_o),
    .rcg_mask_o (rcg_mask_o),
    .blk_mode_o (blk_mode_o)
);

// File: tb/test_mlr_refresh_ctrl.sv
module test_mlr_refresh_ctrl;

    localparam int CLK_P = 10;
    localparam int NB    = 4;
    localparam int R     = 4;
    localparam int NI    = 3;
    localparam int RW    = $clog2(NB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          srch = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_lvl = 1'b0;
    logic [RW-1:0] cfg_relax = '0;
    logic [NB*R-1:0] hit = '0;

    logic [NB-1:0]   pc  [NI];
    logic [NB-1:0]   ok  [NI];
    logic [NB*R-1:0] msk [NI];
    logic [2*NB-1:0] md  [NI];

    int w_of [NI] = '{8, 4, 2};
    int xb_of[NI] = '{0, 1, 0};

    always #(CLK_P/2) clk = ~clk;

    mlr_refresh_ctrl #(.NUM_BLK(NB), .ROWS(R), .BLK_W(8), .XBAR(1'b0)) i_mlr_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .srch_i(srch), .hit_i(hit), .cfg_wr_i(cfg_wr),
        .cfg_relax_i(cfg_relax), .cfg_lvl_i(cfg_lvl), .pc_full_o(pc[0]),
        .srch_ok_o(ok[0]), .rcg_mask_o(msk[0]), .blk_mode_o(md[0]));

    mlr_refresh_ctrl #(.NUM_BLK(NB), .ROWS(R), .BLK_W(4), .XBAR(1'b1)) i_mlr_refresh_ctrl_xb (
        .clk(clk), .rst_n(rst_n), .srch_i(srch), .hit_i(hit), .cfg_wr_i(cfg_wr),
        .cfg_relax_i(cfg_relax), .cfg_lvl_i(cfg_lvl), .pc_full_o(pc[1]),
        .srch_ok_o(ok[1]), .rcg_mask_o(msk[1]), .blk_mode_o(md[1]));

    mlr_refresh_ctrl #(.NUM_BLK(NB), .ROWS(R), .BLK_W(2), .XBAR(1'b0)) i_mlr_refresh_ctrl_nw (
        .clk(clk), .rst_n(rst_n), .srch_i(srch), .hit_i(hit), .cfg_wr_i(cfg_wr),
        .cfg_relax_i(cfg_relax), .cfg_lvl_i(cfg_lvl), .pc_full_o(pc[2]),
        .srch_ok_o(ok[2]), .rcg_mask_o(msk[2]), .blk_mode_o(md[2]));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bit e_pc [NI][NB];
    int e_cnt[NI][NB];
    bit e_acc[NI][NB];
    int obs  [NI][NB];
    int e_relax = 0;
    bit e_lvl = 1'b0;
    bit prev_cfg = 1'b0;
    bit first = 1'b1;
    logic [15:0] lf = 16'hACE1;

    function automatic int exp_mode(int b);
        if (b < e_relax) return e_lvl ? 2 : 1;
        return 0;
    endfunction

    function automatic int exp_per(int k, int m);
        int p;
        p = (w_of[k] >= 8) ? 4 : (w_of[k] >= 4) ? 5 : 7;
        if (m == 1) p = p + ((xb_of[k] != 0) ? 1 : 2);
        if (m == 2) p = p + ((xb_of[k] != 0) ? 3 : 4);
        return p;
    endfunction

    task automatic chk(string tag, int k, int b, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s inst=%0d blk=%0d actual=%0h expected=%0h", tag, k, b, act, exp);
        end
    endtask

    task automatic check_all();
        for (int k = 0; k < NI; k++) begin
            for (int b = 0; b < NB; b++) begin
                logic [R-1:0] emask;
                emask = (e_acc[k][b] && !e_pc[k][b]) ? hit[b*R +: R] : '0;
                if (first) begin
                    chk("R1 charge", k, b, 32'(pc[k][b]), 32'd1);
                    chk("R1 mode", k, b, 32'(md[k][2*b +: 2]), 32'd0);
                    chk("R1 mask", k, b, 32'(msk[k][b*R +: R]), 32'd0);
                end
                if (prev_cfg) chk("R7 forced", k, b, 32'(pc[k][b]), 32'd1);
                chk("R5 R9 strobe", k, b, 32'(pc[k][b]), 32'(e_pc[k][b]));
                chk("R2 accept", k, b, 32'(ok[k][b]), 32'(!e_pc[k][b]));
                chk("R6 R7 mode", k, b, 32'(md[k][2*b +: 2]), 32'(exp_mode(b)));
                chk("R8 mask", k, b, 32'(msk[k][b*R +: R]), 32'(emask));
                if (pc[k][b] && !prev_cfg && !first) begin
                    // a natural refresh: period R3 when exact, R4 when relaxed
                    chk((exp_mode(b) == 0) ? "R3 period" : "R4 period", k, b,
                        32'(obs[k][b]), 32'(exp_per(k, exp_mode(b))));
                end
                if (pc[k][b]) obs[k][b] = 0;
                else if (srch && ok[k][b]) obs[k][b]++;
            end
        end
    endtask

    task automatic update();
        for (int k = 0; k < NI; k++) begin
            for (int b = 0; b < NB; b++) begin
                int per;
                per = exp_per(k, exp_mode(b));
                e_acc[k][b] = srch && !e_pc[k][b];
                if (cfg_wr) begin
                    e_pc[k][b] = 1'b1;
                    e_cnt[k][b] = 0;
                end else if (e_pc[k][b]) begin
                    e_pc[k][b] = 1'b0;
                    e_cnt[k][b] = 0;
                end else if (srch) begin
                    e_cnt[k][b]++;
                    if (e_cnt[k][b] == per) begin
                        e_pc[k][b] = 1'b1;
                        e_cnt[k][b] = 0;
                    end
                end
            end
        end
        if (cfg_wr) begin
            e_relax = int'(cfg_relax);
            e_lvl = cfg_lvl;
        end
        prev_cfg = cfg_wr;
        first = 1'b0;
    endtask

    task automatic cyc(input bit s, input bit cw, input int rl, input bit lv);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        srch = s;
        cfg_wr = cw;
        cfg_relax = RW'(rl);
        cfg_lvl = lv;
        hit = lf;
        #1;
        check_all();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < NI; k++) begin
            for (int b = 0; b < NB; b++) begin
                e_pc[k][b] = 1'b1;
                e_cnt[k][b] = 0;
                e_acc[k][b] = 1'b0;
                obs[k][b] = 0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // exact mode, back-to-back and gapped searches
        for (int i = 0; i < 24; i++) cyc((i % 5) != 3, 1'b0, 0, 1'b0);
        // sweep every relax count (beyond NB too) at both levels
        for (int idx = 0; idx < 16; idx++) begin
            cyc(idx[0], 1'b1, idx >> 1, idx[0]);
            for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 0, 1'b0);     // R9 idle
            for (int i = 0; i < 30; i++) cyc(lf[2:0] != 3'd0, 1'b0, 0, 1'b0);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule